// File: doc/BRIEF.md
# Run-Time Configurable Serial Character Transmitter

This block turns one parallel character into an asynchronous serial frame on a single line. The line rests at logic 1 between frames. The host presents a character and pulses a write strobe. The block then drives a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. Each bit lasts a programmable number of system clocks.

All frame options are inputs that can change at run time: 7 or 8 data bits, parity on or off, even or odd parity, and one or two stop bits. The block copies the bit period and the format into local registers when it accepts a write. A later change on those inputs therefore affects only the next frame. A busy output tells the host when the next write will be taken. An enable input stops the transmitter at any moment. While enable is low, the line sits at idle, busy is low and writes are dropped.

Top module: `uart_tx_serializer`

## Requirements
- R1: After reset, and whenever no frame is in progress, `line_out` is 1 and `busy` is 0.
- R2: A write is accepted when `wr_strobe` is 1, `busy` is 0 and `cfg_enable` is 1 at a rising edge. From the next cycle `busy` is 1 and `line_out` is 0 (start bit) for P cycles, where P is `cfg_period` at acceptance.
- R3: The data bits follow the start bit, least significant first, each lasting P cycles. With `cfg_eight_bits`=1 all 8 bits are sent. With `cfg_eight_bits`=0 only bits 0 to 6 are sent, and bit 7 of `wr_data` has no effect on the line.
- R4: With `cfg_parity_en`=1 one parity bit follows the data. With `cfg_parity_odd`=0 it makes the count of ones in the sent data plus parity even. With `cfg_parity_odd`=1 it makes that count odd.
- R5: With `cfg_parity_en`=0 no parity bit is sent, and `cfg_parity_odd` has no effect on the line or on the frame length.
- R6: The frame ends with stop bits at 1: one when `cfg_two_stop`=0 and two when it is 1.
- R7: `busy` stays 1 for exactly N×P cycles after acceptance, where N = 1 + data bits + parity bits + stop bits. It then falls with `line_out` at 1, and a write in the very next cycle is accepted.
- R8: A strobe while `busy` is 1 is dropped. The frame in progress keeps its bits and its length.
- R9: When `cfg_enable` is 0 at a rising edge, `line_out` is 1 and `busy` is 0 from the next cycle on, and any frame in progress is abandoned. A strobe while `cfg_enable` is 0 starts nothing.
- R10: Changes of `cfg_period`, `cfg_eight_bits`, `cfg_parity_en`, `cfg_parity_odd` or `cfg_two_stop` during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_period | input | 16 | System clocks per bit, 64 or more |
| cfg_eight_bits | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_parity_en | input | 1 | 1: append a parity bit |
| cfg_parity_odd | input | 1 | 0: even parity, 1: odd parity |
| cfg_two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| cfg_enable | input | 1 | 0: transmitter off, line idle |
| wr_strobe | input | 1 | Write request for `wr_data` |
| wr_data | input | 8 | Character to send |
| line_out | output | 1 | Serial output, idles at 1 |
| busy | output | 1 | 1 while a frame is in progress |

## Verification
The strobe input and the running frame can collide in the same cycle. A write can arrive while the frame engine is still shifting, and a configuration change can land in the middle of a frame. The bench provokes both a few cycles into selected frames of the sweep. It pulses the strobe with inverted data and flips every format input and the period at once. It then judges each bit at its centre, and the exact fall of busy, against the frame computed from the settings at acceptance. A second collision is disable against an active frame. That case is judged by the line and busy in the cycle after enable drops.

// File: rtl/uart_tx_pkg.sv
// Package: shared types for the serial character transmitter.
// Assumes: used by the frame engine and the top module only.
package uart_tx_pkg;

    // Frame engine states, in the order bits appear on the line.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } tx_state_e;

    // Character format bundle, sampled when a write is accepted.
    typedef struct packed {
        logic eight_bits;
        logic parity_en;
        logic parity_odd;
        logic two_stop;
    } tx_fmt_t;

endpackage

// File: rtl/uart_tx_bit_timer.sv
// Module: bit-period timer.
// Does: counts system clocks inside one bit and pulses bit_end on the last
//       clock of each bit. The period is captured on load.
// Assumes: period of 2 or more (64 or more in use); load only when idle.
module uart_tx_bit_timer #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [PERIOD_W-1:0] period_in,
    input  logic                active,
    output logic                bit_end
);

    logic [PERIOD_W-1:0] period_q;
    logic [PERIOD_W-1:0] count_q;

    // Last clock of the current bit.
    assign bit_end = active && (count_q == (period_q - PERIOD_W'(1)));

    // Capture the period at frame start and advance the in-bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            count_q  <= '0;
        end else if (load) begin
            period_q <= period_in;
            count_q  <= '0;
        end else if (active && !bit_end) begin
            count_q  <= count_q + PERIOD_W'(1);
        end else begin
            count_q  <= '0;
        end
    end

endmodule

// File: rtl/uart_tx_frame.sv
// Module: frame engine.
// Does: holds the character, walks start, data, parity and stop bits, and
//       drives the registered line and busy outputs.
// Assumes: start is raised only in ST_IDLE; bit_end comes from the timer.
//          A low run forces idle on the next edge.
module uart_tx_frame
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              start,
    input  logic [DATA_W-1:0] data_in,
    input  tx_fmt_t           fmt,
    input  logic              bit_end,
    output logic              line,
    output logic              busy
);

    localparam int IDX_W = $clog2(DATA_W);

    tx_state_e         state_q;
    logic [DATA_W-1:0] shift_q;
    logic [IDX_W-1:0]  idx_q;
    logic              eight_q;
    logic              par_en_q;
    logic              two_stop_q;
    logic              par_bit_q;
    logic              stop_second_q;

    logic [DATA_W-1:0] data_mask;
    logic [DATA_W-1:0] data_masked;
    logic [IDX_W-1:0]  last_idx;

    // Drop the top data bit in the short character size.
    assign data_mask   = fmt.eight_bits ? {DATA_W{1'b1}} : {1'b0, {(DATA_W-1){1'b1}}};
    assign data_masked = data_in & data_mask;
    // Index of the final data bit for the latched size.
    assign last_idx    = eight_q ? IDX_W'(DATA_W-1) : IDX_W'(DATA_W-2);

    // Frame sequencing: load on start, step one bit on each bit_end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            state_q       <= ST_IDLE;
            shift_q       <= '0;
            idx_q         <= '0;
            eight_q       <= 1'b0;
            par_en_q      <= 1'b0;
            two_stop_q    <= 1'b0;
            par_bit_q     <= 1'b0;
            stop_second_q <= 1'b0;
            line          <= 1'b1;
            busy          <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q    <= ST_START;
                        shift_q    <= data_masked;
                        idx_q      <= '0;
                        eight_q    <= fmt.eight_bits;
                        par_en_q   <= fmt.parity_en;
                        two_stop_q <= fmt.two_stop;
                        par_bit_q  <= (^data_masked) ^ fmt.parity_odd;
                        line       <= 1'b0;
                        busy       <= 1'b1;
                    end
                end
                ST_START: begin
                    if (bit_end) begin
                        state_q <= ST_DATA;
                        line    <= shift_q[0];
                        shift_q <= shift_q >> 1;
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        if (idx_q == last_idx) begin
                            if (par_en_q) begin
                                state_q <= ST_PARITY;
                                line    <= par_bit_q;
                            end else begin
                                state_q       <= ST_STOP;
                                stop_second_q <= 1'b0;
                                line          <= 1'b1;
                            end
                        end else begin
                            idx_q   <= idx_q + IDX_W'(1);
                            line    <= shift_q[0];
                            shift_q <= shift_q >> 1;
                        end
                    end
                end
                ST_PARITY: begin
                    if (bit_end) begin
                        state_q       <= ST_STOP;
                        stop_second_q <= 1'b0;
                        line          <= 1'b1;
                    end
                end
                ST_STOP: begin
                    if (bit_end) begin
                        if (two_stop_q && !stop_second_q) begin
                            stop_second_q <= 1'b1;
                        end else begin
                            state_q <= ST_IDLE;
                            busy    <= 1'b0;
                        end
                        line <= 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    line    <= 1'b1;
                    busy    <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/uart_tx_serializer.sv
// Module: top of the serial character transmitter.
// Does: accepts a write when idle and enabled, then times and shapes one
//       frame with the format captured at acceptance.
// Assumes: cfg_period >= 64; the host waits for busy low before writing.
module uart_tx_serializer
    import uart_tx_pkg::*;
#(
    parameter int PERIOD_W = 16,
    parameter int DATA_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  logic                cfg_eight_bits,
    input  logic                cfg_parity_en,
    input  logic                cfg_parity_odd,
    input  logic                cfg_two_stop,
    input  logic                cfg_enable,
    input  logic                wr_strobe,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                line_out,
    output logic                busy
);

    tx_fmt_t fmt;
    logic    accept;
    logic    bit_end;

    // Gather the format inputs into one bundle.
    assign fmt = '{eight_bits: cfg_eight_bits, parity_en: cfg_parity_en,
                   parity_odd: cfg_parity_odd, two_stop: cfg_two_stop};
    // A write counts only when idle and enabled.
    assign accept = wr_strobe && !busy && cfg_enable;

    uart_tx_bit_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .period_in (cfg_period),
        .active    (busy),
        .bit_end   (bit_end)
    );

    uart_tx_frame #(.DATA_W(DATA_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cfg_enable),
        .start   (accept),
        .data_in (wr_data),
        .fmt     (fmt),
        .bit_end (bit_end),
        .line    (line_out),
        .busy    (busy)
    );

endmodule

// File: rtl/uart_tx_checker.sv
// Module: protocol checker for the serial character transmitter.
// Does: watches the top-level ports and flags rule breaks.
// Assumes: bound to every instance of uart_tx_serializer.
module uart_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_enable,
    input logic wr_strobe,
    input logic line_out,
    input logic busy
);

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line_out);                                              // R1

    AST_ACCEPT_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && !busy && cfg_enable) |=> (busy && !line_out));      // R2

    AST_FRAME_ENDS_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && cfg_enable) |-> $past(line_out));                 // R6

    AST_DISABLE_FORCES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (line_out && !busy));                             // R9

    AST_DISABLED_STROBE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && !cfg_enable) |=> !busy);                            // R9

endmodule

bind uart_tx_serializer uart_tx_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .wr_strobe  (wr_strobe),
    .line_out   (line_out),
    .busy       (busy)
);

// File: tb/uart_tx_serializer_bench.sv
// Bench: sweeps every format over a set of characters and checks each bit
// at its centre, the frame length, write collisions, mid-frame format
// changes and disable.
module uart_tx_serializer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BIT_P      = 64;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_period = 16'(BIT_P);
    logic        cfg_eight_bits = 1'b1;
    logic        cfg_parity_en = 1'b0;
    logic        cfg_parity_odd = 1'b0;
    logic        cfg_two_stop = 1'b0;
    logic        cfg_enable = 1'b1;
    logic        wr_strobe = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        line_out;
    logic        busy;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_tx_serializer u_uart_tx_serializer (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_period     (cfg_period),
        .cfg_eight_bits (cfg_eight_bits),
        .cfg_parity_en  (cfg_parity_en),
        .cfg_parity_odd (cfg_parity_odd),
        .cfg_two_stop   (cfg_two_stop),
        .cfg_enable     (cfg_enable),
        .wr_strobe      (wr_strobe),
        .wr_data        (wr_data),
        .line_out       (line_out),
        .busy           (busy)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Send one frame from the current negedge and check it to the end.
    // disturb: strobe again and flip all format inputs early in the frame.
    task automatic run_frame(input logic [7:0] d, input logic eight, input logic pen,
                             input logic podd, input logic two, input int p,
                             input logic disturb);
        logic [15:0] ebits;
        int          n;
        int          nd;
        logic        par;
        logic        busy_ok;
        string       req;
        ebits = '0;
        nd = eight ? 8 : 7;
        n = 0;
        ebits[n] = 1'b0; n++;
        for (int i = 0; i < nd; i++) begin
            ebits[n] = d[i]; n++;
        end
        par = podd;
        for (int i = 0; i < nd; i++) par = par ^ d[i];
        if (pen) begin
            ebits[n] = par; n++;
        end
        ebits[n] = 1'b1; n++;
        if (two) begin
            ebits[n] = 1'b1; n++;
        end
        cfg_period     = 16'(p);
        cfg_eight_bits = eight;
        cfg_parity_en  = pen;
        cfg_parity_odd = podd;
        cfg_two_stop   = two;
        wr_data        = d;
        wr_strobe      = 1'b1;
        @(posedge clk);
        busy_ok = 1'b1;
        for (int c = 0; c < n * p; c++) begin
            @(negedge clk);
            if (c == 0) begin
                wr_strobe = 1'b0;
                wr_data   = 8'h00;
            end
            if (disturb && c == 2) begin
                wr_strobe      = 1'b1;      // R8: collision with a running frame
                wr_data        = ~d;
                cfg_period     = 16'(p + 37); // R10: mid-frame format change
                cfg_eight_bits = ~eight;
                cfg_parity_en  = ~pen;
                cfg_parity_odd = ~podd;
                cfg_two_stop   = ~two;
            end
            if (disturb && c == 3) wr_strobe = 1'b0;
            if (busy !== 1'b1) busy_ok = 1'b0;
            if ((c % p) == p / 2) begin
                int k;
                k = c / p;
                if (disturb) req = "R8/R10";
                else if (k == 0) req = "R2";
                else if (k <= nd) req = "R3";
                else if (pen && k == nd + 1) req = "R4";
                else if (!pen) req = "R5/R6";
                else req = "R6";
                check(req, $sformatf("bit %0d of frame d=%02h cfg=%0d%0d%0d%0d", k, d,
                      eight, pen, podd, two), int'(line_out), int'(ebits[k]));
            end
        end
        check(pen ? "R7" : "R5/R7", $sformatf("busy held for %0d bits", n),
              int'(busy_ok), 1);
        @(negedge clk);
        check("R7", "busy after last stop bit", int'(busy), 0);
        check("R7", "line after last stop bit", int'(line_out), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1", "line in reset", int'(line_out), 1);
        check("R1", "busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "line idle after reset", int'(line_out), 1);
        check("R1", "busy idle after reset", int'(busy), 0);

        // Full format sweep over a set of characters.
        for (int f = 0; f < 16; f++) begin
            for (int di = 0; di < 6; di++) begin
                logic [7:0] dv;
                case (di)
                    0: dv = 8'h00;
                    1: dv = 8'hFF;
                    2: dv = 8'hA5;
                    3: dv = 8'h5A;
                    4: dv = 8'h80;
                    default: dv = 8'h01;
                endcase
                run_frame(dv, f[0], f[1], f[2], f[3], BIT_P, (di == 2) && f[0]);
            end
        end

        // R3: bit 7 has no effect in 7-bit mode (odd parity and length too).
        run_frame(8'hC3, 1'b0, 1'b1, 1'b1, 1'b0, BIT_P, 1'b0);
        run_frame(8'h43, 1'b0, 1'b1, 1'b1, 1'b0, BIT_P, 1'b0);

        // R2: a different bit period.
        run_frame(8'h96, 1'b1, 1'b1, 1'b0, 1'b1, 100, 1'b0);

        // R9: disable in the middle of a frame.
        cfg_period = 16'(BIT_P);
        wr_data    = 8'h3C;
        wr_strobe  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_strobe = 1'b0;
        repeat (3 * BIT_P) @(negedge clk);
        check("R2", "busy before disable", int'(busy), 1);
        cfg_enable = 1'b0;
        @(negedge clk);
        check("R9", "line after disable", int'(line_out), 1);
        check("R9", "busy after disable", int'(busy), 0);
        wr_data   = 8'h00;
        wr_strobe = 1'b1;
        repeat (5) @(negedge clk);
        check("R9", "busy with strobe while disabled", int'(busy), 0);
        check("R9", "line with strobe while disabled", int'(line_out), 1);
        wr_strobe  = 1'b0;
        cfg_enable = 1'b1;
        @(negedge clk);
        check("R9", "busy after re-enable without write", int'(busy), 0);
        run_frame(8'h7E, 1'b1, 1'b0, 1'b0, 1'b0, BIT_P, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R7 watchdog: actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule